// File: doc/BRIEF.md
# Dual-Bank Flash Array Model

This block is a synthesizable, scaled-down model of a NOR-style flash array. It has a synchronous request port instead of a pin-level bus. A request is presented for one cycle with an operation code, an address, a word of write data and a flag that selects the extra block. The block accepts every request on the cycle it is presented and answers on the next cycle with read data and an error flag.

The main array is split into two halves, bank A and bank B. A single timed engine carries out program and erase operations. While the engine works in one bank, reads of the other bank still return array data. Reads of the busy bank return a status word instead of array data. The engine runs one operation at a time, so a second program or erase request is refused while it is busy.

Each block can be protected against writes. Reset clears this per-block protection. There is also a small extra block that lies outside the main address map. Its lock is one-way: once set, nothing clears it, not even reset. The array contents are also kept across reset.

The engine is a three-state machine:
- `ENG_IDLE` goes to `ENG_PROG` on an accepted program, or to `ENG_ERASE` on an accepted erase.
- `ENG_PROG` returns to `ENG_IDLE` after `PROG_CYC` cycles and writes the word in its final cycle.
- `ENG_ERASE` returns to `ENG_IDLE` after `ERASE_CYC` cycles and sets the whole block to ones in its final cycle.

Top module: `dbflash_ctrl`

## Requirements
- R1: Every request with `req_valid` high produces `rsp_valid` high on the next cycle. Read data and the error flag are valid in that same cycle. After reset, `rdy` is 1 and `rsp_valid` is 0.
- R2: At power-up every location, including the extra block, reads as all ones.
- R3: Operation codes are: 0 read, 1 program, 2 erase, 3 protect block, 4 lock extra block. An accepted program holds `rdy` low for exactly `PROG_CYC` cycles. The stored word then becomes the old word AND the new data.
- R4: A program or erase request that arrives while `rdy` is low is answered with `rsp_err` = 1 and has no effect.
- R5: Bank A holds the main addresses with the top address bit 0. Bank B holds those with the top address bit 1. The extra block belongs to bank A. A read of the bank that is not busy returns array data, including in the cycle the engine finishes.
- R6: A read of the busy bank returns a status word instead of array data. In that word, bit DW-1 is 1. Bit DW-2 starts at 0 for each operation and inverts after every status read. Bit DW-3 is 1 when the program data has a 1 where the old word has a 0. All other bits are 0.
- R7: A protect request marks the block that holds the address. A later program or erase of that block is answered with `rsp_err` = 1 and leaves the contents unchanged.
- R8: An accepted erase holds `rdy` low for `ERASE_CYC` cycles and then sets every word of the addressed block to ones. No other block is touched. With the small blocks at the bottom (the default), words 0 to 15 form four 4-word blocks and words 16 to 63 form three 16-word blocks.
- R9: With `req_ext` = 1, the low three address bits select a word of the 8-word extra block. After a lock-extra request, any program or erase of the extra block is refused with `rsp_err` = 1. This refusal still holds after reset.
- R10: Reset clears every per-block protection. Reset leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_ext | input | 1 | Selects the extra block |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Program data |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DW | Read data or status word |
| rsp_err | output | 1 | Request refused |
| rdy | output | 1 | High when no operation is running |

## Verification
Two things can happen in the same cycle: the engine commits an erase in bank B, and a read arrives. The bench provokes this by issuing an erase and then one read on every following cycle, so that the last read lands on the commit edge.

The bench judges the result as follows:
- Every bank A read in that window must return stored data.
- A bank B read that lands on the commit edge must still return the status word.
- A bank B read one cycle later must return the erased value.

Together these checks pin down the erase length to the exact cycle.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_PROG  = 3'd1,
        OP_ERASE = 3'd2,
        OP_LOCK  = 3'd3,
        OP_LOCKX = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_PROG  = 2'd1,
        ENG_ERASE = 2'd2
    } eng_state_e;
endpackage

// File: rtl/dbf_blkmap.sv
module dbf_blkmap #(
    parameter int AW        = 6,
    parameter int PB_WORDS  = 4,
    parameter int NPB       = 4,
    parameter int MB_WORDS  = 16,
    parameter bit PARAM_TOP = 1'b0,
    parameter int BW        = 3
) (
    input  logic [AW-1:0] addr,
    output logic [BW-1:0] blk,
    output logic [AW-1:0] base,
    output logic [AW:0]   size
);
    localparam int WORDS = 2 ** AW;
    localparam int PREG  = NPB * PB_WORDS;
    localparam int NMB   = (WORDS - PREG) / MB_WORDS;
    localparam int MEND  = WORDS - PREG;

    generate
        if (PARAM_TOP == 1'b0) begin : g_small_low
            always_comb begin
                int a;
                int b;
                a = int'(addr);
                if (a < PREG) begin
                    b    = a / PB_WORDS;
                    base = AW'(b * PB_WORDS);
                    size = (AW+1)'(PB_WORDS);
                end else begin
                    b    = NPB + (a - PREG) / MB_WORDS;
                    base = AW'(PREG + (b - NPB) * MB_WORDS);
                    size = (AW+1)'(MB_WORDS);
                end
                blk = BW'(b);
            end
        end else begin : g_small_high
            always_comb begin
                int a;
                int b;
                a = int'(addr);
                if (a < MEND) begin
                    b    = a / MB_WORDS;
                    base = AW'(b * MB_WORDS);
                    size = (AW+1)'(MB_WORDS);
                end else begin
                    b    = NMB + (a - MEND) / PB_WORDS;
                    base = AW'(MEND + (b - NMB) * PB_WORDS);
                    size = (AW+1)'(PB_WORDS);
                end
                blk = BW'(b);
            end
        end
    endgenerate
endmodule

// File: rtl/dbf_engine.sv
module dbf_engine
    import dbf_pkg::*;
#(
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    output logic busy,
    output logic commit_prog,
    output logic commit_erase
);
    localparam int CW = $clog2(ERASE_CYC + 1);

    eng_state_e st, st_nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ENG_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ENG_IDLE: begin
                if (start_prog)       st_nxt = ENG_PROG;
                else if (start_erase) st_nxt = ENG_ERASE;
            end
            ENG_PROG, ENG_ERASE: begin
                if (cnt == '0) st_nxt = ENG_IDLE;
            end
            default: st_nxt = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (st == ENG_IDLE) begin
            cnt <= start_prog ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        busy         = (st != ENG_IDLE);
        commit_prog  = (st == ENG_PROG)  && (cnt == '0);
        commit_erase = (st == ENG_ERASE) && (cnt == '0);
    end

    assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |-> (st == ENG_IDLE));

    assert_commit_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_prog || commit_erase) |=> (st == ENG_IDLE));
endmodule

// File: rtl/dbflash_ctrl.sv
module dbflash_ctrl
    import dbf_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 6,
    parameter int XAW       = 3,
    parameter int PB_WORDS  = 4,
    parameter int NPB       = 4,
    parameter int MB_WORDS  = 16,
    parameter bit PARAM_TOP = 1'b0,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic          req_ext,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_err,
    output logic          rdy
);
    localparam int WORDS  = 2 ** AW;
    localparam int XWORDS = 2 ** XAW;
    localparam int TOTAL  = WORDS + XWORDS;
    localparam int MAW    = $clog2(TOTAL);
    localparam int NMB    = (WORDS - NPB * PB_WORDS) / MB_WORDS;
    localparam int NBLK   = NPB + NMB;
    localparam int BW     = $clog2(NBLK);

    // Non-volatile state: no reset.
    logic [DW-1:0] mem [TOTAL] = '{default: '1};
    logic          xlock = 1'b0;

    logic [NBLK-1:0] prot;
    op_e             op;
    logic [BW-1:0]   blk;
    logic [AW-1:0]   bbase;
    logic [AW:0]     bsize;
    logic [MAW-1:0]  mem_idx;
    logic            req_bank, is_wr, blocked, accept;
    logic            start_prog, start_erase;
    logic            busy, commit_prog, commit_erase;
    logic [MAW-1:0]  op_idx, er_lo;
    logic [MAW:0]    er_sz;
    logic [DW-1:0]   op_data, status;
    logic            op_bank, perr, tog, rd_req, rd_status;

    assign op = op_e'(req_op);

    dbf_blkmap #(
        .AW(AW), .PB_WORDS(PB_WORDS), .NPB(NPB), .MB_WORDS(MB_WORDS),
        .PARAM_TOP(PARAM_TOP), .BW(BW)
    ) u_map (
        .addr(req_addr), .blk(blk), .base(bbase), .size(bsize)
    );

    dbf_engine #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start_prog(start_prog), .start_erase(start_erase),
        .busy(busy), .commit_prog(commit_prog), .commit_erase(commit_erase)
    );

    always_comb begin
        mem_idx     = req_ext ? (MAW'(WORDS) + MAW'(req_addr[XAW-1:0])) : MAW'(req_addr);
        req_bank    = req_ext ? 1'b0 : req_addr[AW-1];
        is_wr       = req_valid && (op == OP_PROG || op == OP_ERASE);
        blocked     = req_ext ? xlock : prot[blk];
        accept      = is_wr && !busy && !blocked;
        start_prog  = accept && (op == OP_PROG);
        start_erase = accept && (op == OP_ERASE);
        rd_req      = req_valid && (op == OP_READ);
        rd_status   = busy && (req_bank == op_bank);
        status          = '0;
        status[DW-1]    = 1'b1;
        status[DW-2]    = tog;
        status[DW-3]    = perr;
        rdy             = !busy;
    end

    // Operation latch and status bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_idx  <= '0;
            op_data <= '0;
            op_bank <= 1'b0;
            er_lo   <= '0;
            er_sz   <= '0;
            perr    <= 1'b0;
            tog     <= 1'b0;
        end else if (accept) begin
            op_idx  <= mem_idx;
            op_data <= req_wdata;
            op_bank <= req_bank;
            er_lo   <= req_ext ? MAW'(WORDS) : MAW'(bbase);
            er_sz   <= req_ext ? (MAW+1)'(XWORDS) : (MAW+1)'(bsize);
            perr    <= start_prog && (|(~mem[mem_idx] & req_wdata));
            tog     <= 1'b0;
        end else if (rd_req && rd_status) begin
            tog     <= ~tog;
        end
    end

    // Response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= is_wr && !accept;
            rsp_data  <= rd_req ? (rd_status ? status : mem[mem_idx]) : '0;
        end
    end

    // Per-block protection (volatile)
    always_ff @(posedge clk) begin
        if (!rst_n) prot <= '0;
        else if (req_valid && op == OP_LOCK && !req_ext) prot[blk] <= 1'b1;
    end

    // One-way lock of the extra block
    always_ff @(posedge clk) begin
        if (req_valid && op == OP_LOCKX) xlock <= 1'b1;
    end

    // Array update
    always_ff @(posedge clk) begin
        for (int i = 0; i < TOTAL; i++) begin
            if (commit_erase && i >= int'(er_lo) && i < int'(er_lo) + int'(er_sz))
                mem[i] <= '1;
        end
        if (commit_prog) mem[op_idx] <= mem[op_idx] & op_data;
    end

    assert_rsp_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_busy_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && busy) |=> rsp_err);

    assert_prot_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && !req_ext && prot[blk]) |=> rsp_err);

    assert_xlock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xlock |=> xlock);
endmodule

// File: tb/test_dbflash_ctrl.sv
module test_dbflash_ctrl;
    localparam int DW = 16;
    localparam int AW = 6;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = 3'd0;
    logic          req_ext = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid, rsp_err, rdy;
    logic [DW-1:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    dbflash_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_dbflash_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_ext(req_ext), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .rdy(rdy)
    );

    // {tag(4), op(3), ext(1), addr(6), wdata(16), expected data(16), expected err(1)}
    localparam int NV = 24;
    localparam logic [46:0] VEC [NV] = '{
        {4'd2,  3'd0, 1'b0, 6'd5,  16'h0000, 16'hFFFF, 1'b0}, // R2 erased at power-up
        {4'd3,  3'd1, 1'b0, 6'd5,  16'hA5A5, 16'h0000, 1'b0}, // R3 program
        {4'd3,  3'd0, 1'b0, 6'd5,  16'h0000, 16'hA5A5, 1'b0}, // R3
        {4'd3,  3'd1, 1'b0, 6'd5,  16'h0FF0, 16'h0000, 1'b0}, // R3 AND rule
        {4'd3,  3'd0, 1'b0, 6'd5,  16'h0000, 16'h05A0, 1'b0}, // R3
        {4'd3,  3'd1, 1'b0, 6'd20, 16'h1234, 16'h0000, 1'b0},
        {4'd3,  3'd0, 1'b0, 6'd20, 16'h0000, 16'h1234, 1'b0},
        {4'd3,  3'd1, 1'b0, 6'd8,  16'h5555, 16'h0000, 1'b0},
        {4'd8,  3'd2, 1'b0, 6'd4,  16'h0000, 16'h0000, 1'b0}, // R8 erase block 4..7
        {4'd8,  3'd0, 1'b0, 6'd5,  16'h0000, 16'hFFFF, 1'b0}, // R8
        {4'd8,  3'd0, 1'b0, 6'd8,  16'h0000, 16'h5555, 1'b0}, // R8 neighbour kept
        {4'd8,  3'd0, 1'b0, 6'd20, 16'h0000, 16'h1234, 1'b0},
        {4'd7,  3'd3, 1'b0, 6'd20, 16'h0000, 16'h0000, 1'b0}, // R7 protect 16..31
        {4'd7,  3'd1, 1'b0, 6'd21, 16'h0000, 16'h0000, 1'b1}, // R7
        {4'd7,  3'd0, 1'b0, 6'd21, 16'h0000, 16'hFFFF, 1'b0}, // R7
        {4'd7,  3'd2, 1'b0, 6'd20, 16'h0000, 16'h0000, 1'b1}, // R7
        {4'd7,  3'd0, 1'b0, 6'd20, 16'h0000, 16'h1234, 1'b0}, // R7
        {4'd9,  3'd1, 1'b1, 6'd2,  16'hBEEF, 16'h0000, 1'b0}, // R9
        {4'd9,  3'd0, 1'b1, 6'd2,  16'h0000, 16'hBEEF, 1'b0}, // R9
        {4'd9,  3'd4, 1'b1, 6'd0,  16'h0000, 16'h0000, 1'b0}, // R9 lock
        {4'd9,  3'd1, 1'b1, 6'd3,  16'h0000, 16'h0000, 1'b1}, // R9
        {4'd9,  3'd0, 1'b1, 6'd3,  16'h0000, 16'hFFFF, 1'b0}, // R9
        {4'd9,  3'd2, 1'b1, 6'd0,  16'h0000, 16'h0000, 1'b1}, // R9
        {4'd9,  3'd0, 1'b1, 6'd2,  16'h0000, 16'hBEEF, 1'b0}  // R9
    };

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request; returns at the negedge where the response is visible.
    task automatic do_req(input logic [2:0] op, input logic ext, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
        req_valid = 1'b1; req_op = op; req_ext = ext; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle;
        while (!rdy) @(negedge clk);
    endtask

    task automatic read_chk(input logic ext, input logic [AW-1:0] a,
                            input logic [DW-1:0] exp, input string req);
        do_req(3'd0, ext, a, '0);
        check(rsp_valid && rsp_data == exp, req, rsp_data, exp);
    endtask

    task automatic wr_chk(input logic [2:0] op, input logic ext, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic exp_err, input string req);
        do_req(op, ext, a, d);
        check(rsp_valid && rsp_err == exp_err, req, {15'd0, rsp_err}, {15'd0, exp_err});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rdy == 1'b1, "R1 rdy after reset", {15'd0, rdy}, 16'd1);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", {15'd0, rsp_valid}, 16'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            automatic logic [46:0] v = VEC[i];
            automatic string tag = $sformatf("R%0d vector %0d", v[46:43], i);
            do_req(v[42:40], v[39], v[38:33], v[32:17]);
            if (v[42:40] == 3'd0)
                check(rsp_valid && rsp_data == v[16:1] && !rsp_err, tag, rsp_data, v[16:1]);
            else
                check(rsp_valid && rsp_err == v[0], tag, {15'd0, rsp_err}, {15'd0, v[0]});
            wait_idle();
        end

        // R3 program duration
        begin
            int lowc = 0;
            do_req(3'd1, 1'b0, 6'd33, 16'h00FF);
            while (!rdy) begin lowc++; @(negedge clk); end
            check(lowc == PROG_CYC, "R3 busy length", 16'(lowc), 16'(PROG_CYC));
            read_chk(1'b0, 6'd33, 16'h00FF, "R3 readback");
        end

        // R6 status, R5 other bank, R4 busy reject
        wr_chk(3'd1, 1'b0, 6'd33, 16'h0F00, 1'b0, "R3 accept");
        read_chk(1'b0, 6'd34, 16'hA000, "R6 status first");
        read_chk(1'b0, 6'd34, 16'hE000, "R6 status toggled");
        read_chk(1'b0, 6'd20, 16'h1234, "R5 other bank");
        wr_chk(3'd1, 1'b0, 6'd10, 16'h0000, 1'b1, "R4 program while busy");
        wr_chk(3'd2, 1'b0, 6'd0, 16'h0000, 1'b1, "R4 erase while busy");
        wait_idle();
        read_chk(1'b0, 6'd33, 16'h0000, "R3 AND result");
        read_chk(1'b0, 6'd10, 16'hFFFF, "R4 no effect");

        // Erase in bank B with reads each cycle up to the commit edge
        wr_chk(3'd2, 1'b0, 6'd48, 16'h0000, 1'b0, "R8 erase accept");
        for (int k = 1; k < ERASE_CYC; k++)
            read_chk(1'b0, 6'd20, 16'h1234, "R5 read during erase");
        read_chk(1'b0, 6'd55, 16'h8000, "R6 status at commit edge");
        read_chk(1'b0, 6'd55, 16'hFFFF, "R8 erased after ERASE_CYC");
        read_chk(1'b0, 6'd33, 16'h0000, "R8 other block kept");

        // Reset behaviour
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdy == 1'b1 && rsp_valid == 1'b0, "R1 after second reset",
              {14'd0, rdy, rsp_valid}, 16'h0002);
        read_chk(1'b0, 6'd20, 16'h1234, "R10 contents kept");
        wr_chk(3'd1, 1'b0, 6'd21, 16'h0000, 1'b0, "R10 protection cleared");
        wait_idle();
        read_chk(1'b0, 6'd21, 16'h0000, "R10 program after reset");
        wr_chk(3'd1, 1'b1, 6'd3, 16'h0000, 1'b1, "R9 lock survives reset");
        read_chk(1'b1, 6'd3, 16'hFFFF, "R9 extra unchanged");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule